// File: doc/BRIEF.md
# Key-Protected Reset Control Register

This block is a single 32-bit control register on a plain register bus. A write can change it only when the upper halfword of the write data carries the unlock key 0x05FA. A write with any other upper halfword is dropped as a whole. Reads always show the constant 0xFA05 in the upper halfword, so software cannot read the unlock key back.

The register holds three things: a 3-bit priority-grouping field, a secure-only gate for the reset request, and an enable that sends certain fault and NMI exceptions to the non-secure state. It also has one write-only bit. Writing that bit as 1 with a valid key produces a one-cycle system reset request. When the secure-only gate is set, a non-secure access cannot raise that request. The gate and the non-secure-target enable change only through secure accesses. The field values also appear on dedicated outputs for the logic that consumes them.

Top module: `keyed_rst_ctl_reg`

## Requirements
- R1: After reset the register reads 0xFA050000 at its address, and `sys_rst_req`, `prio_group`, `sec_rst_only` and `ns_fault_tgt` are all 0.
- R2: A write whose data bits 31:16 are not 0x05FA changes no field and raises no reset request.
- R3: A read at the register address returns 0xFA05 in bits 31:16, whatever was last written there.
- R4: A keyed write from either security state loads bits 10:8 of the write data into the priority-grouping field. That field reads back in bits 10:8 and drives `prio_group`.
- R5: A keyed write with bit 2 set raises `sys_rst_req` for exactly one cycle, in the cycle that follows the accepting clock edge (unless R6 blocks it). Bit 2 always reads 0.
- R6: While the secure-only gate (bit 3) is 1, a non-secure keyed write with bit 2 set raises no reset request. A secure one still does.
- R7: Bits 3 and 13 are loaded only by secure keyed writes. They read back in bits 3 and 13 and drive `sec_rst_only` and `ns_fault_tgt`. A non-secure keyed write leaves both unchanged and still updates bits 10:8.
- R8: Bits 15, 14, 12:11, 7:4, 1 and 0 always read 0.
- R9: An access with `bus_addr` different from `REG_ADDR` reads as 0, changes no field and raises no reset request.

Top module ports are listed in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data: unlock key in 31:16, fields below |
| bus_secure | input | 1 | 1 when the access comes from the secure state |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| sys_rst_req | output | 1 | One-cycle system reset request |
| prio_group | output | 3 | Priority-grouping field |
| sec_rst_only | output | 1 | Secure-only gate for the reset request |
| ns_fault_tgt | output | 1 | Fault and NMI exceptions target the non-secure state |

## Verification
The hardest case to reach is a non-secure access that tries to request a reset while the gate is set. Only a secure keyed write can set the gate beforehand. A non-secure attempt to clear the gate in the same write must also fail.

The bench sweeps every combination of the priority-grouping value, the request bit, the gate bit and the target bit. It runs that sweep for both security states and for several good and bad keys, so each gate state meets each kind of requester. It predicts every pulse and every readback from its own model of the fields.

// File: rtl/krc_pkg.sv
package krc_pkg;
  localparam int DATA_W      = 32;
  localparam int KEY_W       = 16;
  localparam int KEY_LSB     = DATA_W - KEY_W;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h05FA;
  localparam logic [KEY_W-1:0] READ_SIG   = 16'hFA05;
  localparam int PG_W        = 3;
  localparam int PG_LSB      = 8;
  localparam int NST_BIT     = 13;
  localparam int GATE_BIT    = 3;
  localparam int REQ_BIT     = 2;

  typedef struct packed {
    logic            ns_tgt;
    logic            gate;
    logic [PG_W-1:0] pg;
  } krc_fields_t;
endpackage

// File: rtl/krc_rst_sync.sv
module krc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/krc_decode.sv
module krc_decode
  import krc_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic              bus_secure,
  output logic              hit,
  output logic              wr_ok,
  output logic              sec_wr_ok
);
  logic key_match;

  always_comb begin
    hit       = (bus_addr == REG_ADDR);
    key_match = (wr_key == UNLOCK_KEY);
    wr_ok     = bus_wr && hit && key_match;
    sec_wr_ok = wr_ok && bus_secure;
  end
endmodule

// File: rtl/krc_fields.sv
module krc_fields
  import krc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ok,
  input  logic            sec_wr_ok,
  input  logic [PG_W-1:0] wr_pg,
  input  logic            wr_gate,
  input  logic            wr_nst,
  output krc_fields_t     fields
);
  krc_fields_t fld_q, fld_d;
  logic        pg_en, sec_en;

  always_comb begin
    pg_en  = wr_ok;
    sec_en = sec_wr_ok;
    fld_d  = fld_q;
    if (pg_en) fld_d.pg = wr_pg;
    if (sec_en) begin
      fld_d.gate   = wr_gate;
      fld_d.ns_tgt = wr_nst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fld_q <= '0;
    else if (pg_en || sec_en) fld_q <= fld_d;
  end

  assign fields = fld_q;
endmodule

// File: rtl/krc_pulse.sv
module krc_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ok,
  input  logic req_bit,
  input  logic secure,
  input  logic gate,
  output logic pulse
);
  logic pulse_q, pulse_d;

  always_comb begin
    pulse_d = wr_ok && req_bit && (secure || !gate);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/krc_rdfmt.sv
module krc_rdfmt
  import krc_pkg::*;
(
  input  logic              hit,
  input  krc_fields_t       fields,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word                       = '0;
    word[KEY_LSB +: KEY_W]     = READ_SIG;
    word[PG_LSB +: PG_W]       = fields.pg;
    word[GATE_BIT]             = fields.gate;
    word[NST_BIT]              = fields.ns_tgt;
    rdata                      = hit ? word : '0;
  end
endmodule

// File: rtl/keyed_rst_ctl_reg.sv
module keyed_rst_ctl_reg
  import krc_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h10,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_secure,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst_req,
  output logic [2:0]        prio_group,
  output logic              sec_rst_only,
  output logic              ns_fault_tgt
);
  logic        rst_int_n;
  logic        hit, wr_ok, sec_wr_ok;
  krc_fields_t fields;

  krc_rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  krc_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_dec (
    .bus_addr(bus_addr), .bus_wr(bus_wr),
    .wr_key(bus_wdata[KEY_LSB +: KEY_W]), .bus_secure(bus_secure),
    .hit(hit), .wr_ok(wr_ok), .sec_wr_ok(sec_wr_ok)
  );

  krc_fields i_fld (
    .clk(clk), .rst_n(rst_int_n), .wr_ok(wr_ok), .sec_wr_ok(sec_wr_ok),
    .wr_pg(bus_wdata[PG_LSB +: PG_W]), .wr_gate(bus_wdata[GATE_BIT]),
    .wr_nst(bus_wdata[NST_BIT]), .fields(fields)
  );

  krc_pulse i_pls (
    .clk(clk), .rst_n(rst_int_n), .wr_ok(wr_ok), .req_bit(bus_wdata[REQ_BIT]),
    .secure(bus_secure), .gate(fields.gate), .pulse(sys_rst_req)
  );

  krc_rdfmt i_rd (.hit(hit), .fields(fields), .rdata(bus_rdata));

  assign prio_group   = fields.pg;
  assign sec_rst_only = fields.gate;
  assign ns_fault_tgt = fields.ns_tgt;
endmodule

// File: rtl/krc_checker.sv
module krc_checker #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              bus_secure,
  input logic [31:0]       bus_rdata,
  input logic              sys_rst_req,
  input logic [2:0]        prio_group,
  input logic              sec_rst_only,
  input logic              ns_fault_tgt
);
  // R2
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[31:16] != 16'h05FA) |=>
      ($stable(prio_group) && $stable(sec_rst_only) && $stable(ns_fault_tgt) && !sys_rst_req));

  // R3
  read_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_ADDR) |-> (bus_rdata[31:16] == 16'hFA05));

  // R5
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(bus_wr && bus_addr == REG_ADDR && bus_wdata[2]));

  // R6
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_secure && sec_rst_only) |=> !sys_rst_req);

  // R7
  ns_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_secure) |=> ($stable(sec_rst_only) && $stable(ns_fault_tgt)));

  // R8
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[15:14] == 2'b00 && bus_rdata[12:11] == 2'b00 &&
     bus_rdata[7:4] == 4'h0 && bus_rdata[2:0] == 3'b000));

  // R9
  miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != REG_ADDR) |-> (bus_rdata == 32'h0));
endmodule

bind keyed_rst_ctl_reg krc_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_krc_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_secure(bus_secure), .bus_rdata(bus_rdata),
  .sys_rst_req(sys_rst_req), .prio_group(prio_group),
  .sec_rst_only(sec_rst_only), .ns_fault_tgt(ns_fault_tgt)
);

// File: tb/test_keyed_rst_ctl_reg.sv
`timescale 1ns/1ps
module test_keyed_rst_ctl_reg;
  localparam logic [7:0] RA = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_secure;
  logic [31:0] bus_rdata;
  logic        sys_rst_req;
  logic [2:0]  prio_group;
  logic        sec_rst_only;
  logic        ns_fault_tgt;

  int tests = 0;
  int fails = 0;
  logic       done = 1'b0;
  logic [2:0] m_pg;
  logic       m_gate, m_nst;

  always #2.5 clk = ~clk;

  keyed_rst_ctl_reg i_keyed_rst_ctl_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_secure(bus_secure), .bus_rdata(bus_rdata),
    .sys_rst_req(sys_rst_req), .prio_group(prio_group),
    .sec_rst_only(sec_rst_only), .ns_fault_tgt(ns_fault_tgt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    return {16'hFA05, 2'b00, m_nst, 2'b00, m_pg, 4'h0, m_gate, 3'b000};
  endfunction

  task automatic check_state(input string req);
    bus_addr = RA;
    #0.1;
    check(req, bus_rdata, exp_word());
    check(req, {28'h0, prio_group, 1'b0}, {28'h0, m_pg, 1'b0});
    check(req, {30'h0, sec_rst_only, ns_fault_tgt}, {30'h0, m_gate, m_nst});
  endtask

  // one write: drive at negedge, accepting edge, sample pulse, then its end
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic sec, input string req);
    logic ok, exp_p;
    ok    = (a == RA) && (d[31:16] == 16'h05FA);
    exp_p = ok && d[2] && (sec || !m_gate);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_secure = sec; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (ok) begin
      m_pg = d[10:8];
      if (sec) begin m_gate = d[3]; m_nst = d[13]; end
    end
    check({req, " pulse"}, {31'h0, sys_rst_req}, {31'h0, exp_p});
    @(negedge clk);
    check({req, " pulse end"}, {31'h0, sys_rst_req}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = RA; bus_wr = 1'b0; bus_wdata = '0; bus_secure = 1'b0;
    m_pg = '0; m_gate = 1'b0; m_nst = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", bus_rdata, 32'hFA050000);
    check("R1", {28'h0, prio_group, sys_rst_req}, 32'h0);
    check("R1", {30'h0, sec_rst_only, ns_fault_tgt}, 32'h0);

    // R2 R4 R5 R6 R7 R8 sweep: keys x security x field combinations
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 2; s++) begin
        for (int v = 0; v < 64; v++) begin
          logic [15:0] key;
          logic [31:0] d;
          case (k)
            0: key = 16'h05FA;
            1: key = 16'hFA05;
            2: key = 16'h0000;
            default: key = 16'h05FB;
          endcase
          // bits 15,14,12,11,7:4,1,0 also driven high to prove they read 0 (R8)
          d = {key, 2'b11, v[5], 2'b11, v[2:0], 4'hF, v[4], v[3], 2'b11};
          wr(RA, d, s[0], (k == 0) ? "R4/R5/R6/R7" : "R2");
          check_state((k == 0) ? "R3/R4/R7/R8" : "R2/R3");
        end
      end
    end

    // R6 directed: gate set by secure write, non-secure request blocked, secure honoured
    wr(RA, 32'h05FA_0008, 1'b1, "R6 set gate");
    check("R6 gate", {31'h0, sec_rst_only}, 32'h1);
    wr(RA, 32'h05FA_0004, 1'b0, "R6 ns blocked");
    wr(RA, 32'h05FA_000C, 1'b1, "R6 secure honoured");
    // R7 non-secure tries to clear gate and set target, only pg changes
    wr(RA, 32'h05FA_2504, 1'b0, "R7 ns write");
    check_state("R7");

    // R9 other addresses: writes ignored, reads 0
    for (int a = 0; a < 256; a += 17) begin
      if (a[7:0] != RA) begin
        wr(a[7:0], 32'h05FA_2704, 1'b1, "R9 miss write");
        bus_addr = a[7:0];
        #0.1;
        check("R9 miss read", bus_rdata, 32'h0);
      end
    end
    check_state("R9");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule